// File: doc/BRIEF.md
# Cache Timing Model

This block times the memory operations of a functional processor model. It keeps no data. For every modelled core it keeps a private tag store: a tag, a valid bit, a dirty bit and an age per way. Each request carries a core number, an address and a load/store flag. The block looks the address up in that core's tag store and replies with the number of target cycles the core must stall. A hit costs nothing. A miss costs a configurable penalty, plus a second configurable penalty when the line it replaces is dirty.

The modelled geometry is read from configuration inputs at run time: line size, set count, associativity, and both penalties. One build can therefore model a direct-mapped cache and a set-associative cache, within a fixed maximum of host storage. Because only metadata is held, the modelled capacity can be far larger than the host storage. Per-core hit and miss counters let the functional side measure a run.

Top module: `cacheTimingModel`

## Requirements
- R1: While and after reset, respValid is 0 and every hit and miss counter reads 0.
- R2: Every request cycle is answered exactly one clock later by respValid=1 with respCore equal to the requesting core. A cycle without a request is followed by respValid=0.
- R3: A lookup that matches a valid line of the requesting core's selected set answers respHit=1 and respStall=0.
- R4: A miss whose replaced way is invalid or clean answers respHit=0 and respStall equal to cfgMissPenalty as sampled in the request cycle.
- R5: A store marks its line dirty, whether it hits or fills on a miss. A miss that replaces a dirty line answers cfgMissPenalty+cfgWbPenalty.
- R6: Address bits [cfgLineLog2-1:0] are the offset and are ignored. The next cfgSetsLog2 bits select the set. All bits above those form the tag. Lines in different sets never evict each other.
- R7: A set holds 2^cfgWaysLog2 lines. That many conflicting lines coexist, and ways beyond that count are never hit or filled.
- R8: A miss fills the lowest-numbered invalid way if one exists. Otherwise it fills the least recently accessed way of the set. Both hits and fills count as accesses.
- R9: Each core has its own tag store, so a line filled by one core is a miss for another core.
- R10: A change of any geometry input (sets, ways or line size, after clamping) invalidates every line. A change of the penalty inputs alone keeps all lines.
- R11: hitCount and missCount hold one 16-bit counter per core, core c in bits [16c+15:16c]. A response increments the counter matching its outcome. statClear zeroes all counters, and it wins over an increment in the same cycle.
- R12: A cfgSetsLog2 or cfgWaysLog2 value above the built maximum (4 and 2 by default) acts as that maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgSetsLog2 | input | 3 | log2 of modelled set count |
| cfgWaysLog2 | input | 2 | log2 of modelled associativity |
| cfgLineLog2 | input | 3 | log2 of modelled line size in bytes |
| cfgMissPenalty | input | 16 | Stall cycles charged for a miss |
| cfgWbPenalty | input | 16 | Extra stall cycles when a dirty line is replaced |
| reqValid | input | 1 | Memory operation present this cycle |
| reqCore | input | 2 | Issuing core |
| reqAddr | input | 32 | Byte address |
| reqStore | input | 1 | 1 for a store, 0 for a load |
| statClear | input | 1 | Zero all hit and miss counters |
| respValid | output | 1 | Response present |
| respCore | output | 2 | Core the response belongs to |
| respHit | output | 1 | Lookup hit |
| respStall | output | 17 | Target stall cycles |
| hitCount | output | 64 | Per-core hit counters, 16 bits each |
| missCount | output | 64 | Per-core miss counters, 16 bits each |

## Verification
A corrupted tag, valid bit or dirty bit appears at the next access to that set by that core, as a wrong respHit or as a stall that is off by exactly one penalty. A damaged age field does not show until the set is full and a conflicting miss picks its victim. The bench therefore fills sets completely and then counts the misses needed to re-expose a specific line. Failure to flush on a geometry change shows on the first access after the change, as a hit where a miss is required.

// File: rtl/cacheModelPkg.sv
package cacheModelPkg;
  // strobes from the control side to the tag store
  typedef struct packed {
    logic flushAll;  // drop every line this cycle
    logic access;    // perform lookup-and-update this cycle
    logic storeOp;   // access is a store
  } tagStrobe_t;
endpackage

// File: rtl/cacheTagStore.sv
module cacheTagStore
  import cacheModelPkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int CORE_W        = 2,
  parameter int ADDR_W        = 32,
  parameter int MAX_SETS_LOG2 = 4,
  parameter int MAX_WAYS_LOG2 = 2,
  parameter int SCFG_W        = 3,
  parameter int WCFG_W        = 2,
  parameter int LCFG_W        = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  tagStrobe_t        strobes,
  input  logic [CORE_W-1:0] reqCore,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [SCFG_W-1:0] setsLog2,
  input  logic [WCFG_W-1:0] waysLog2,
  input  logic [LCFG_W-1:0] lineLog2,
  output logic              lookHit,
  output logic              lookVictimDirty
);
  localparam int MAX_SETS = 1 << MAX_SETS_LOG2;
  localparam int MAX_WAYS = 1 << MAX_WAYS_LOG2;
  localparam int SET_W    = (MAX_SETS_LOG2 > 0) ? MAX_SETS_LOG2 : 1;
  localparam int WAY_W    = (MAX_WAYS_LOG2 > 0) ? MAX_WAYS_LOG2 : 1;
  localparam int NW_W     = WAY_W + 1;

  logic [ADDR_W-1:0] tagArr   [NUM_CORES][MAX_SETS][MAX_WAYS];
  logic              validArr [NUM_CORES][MAX_SETS][MAX_WAYS];
  logic              dirtyArr [NUM_CORES][MAX_SETS][MAX_WAYS];
  logic [WAY_W-1:0]  ageArr   [NUM_CORES][MAX_SETS][MAX_WAYS];

  logic [SET_W-1:0]  setMask, setIdx;
  logic [7:0]        tagShift;
  logic [ADDR_W-1:0] reqTag;
  logic [NW_W-1:0]   numWays;

  assign setMask  = SET_W'((1 << setsLog2) - 1);
  assign setIdx   = SET_W'(reqAddr >> lineLog2) & setMask;
  assign tagShift = 8'(lineLog2) + 8'(setsLog2);
  assign reqTag   = reqAddr >> tagShift;
  assign numWays  = NW_W'(1) << waysLog2;

  logic [MAX_WAYS-1:0] wayOn, hitVec, freeVec;
  logic [WAY_W-1:0]    curAge [MAX_WAYS];
  logic [WAY_W-1:0]    hitWay, freeWay, lruWay, useWay, useAge;
  logic                anyFree;

  always_comb begin
    for (int w = 0; w < MAX_WAYS; w++) begin
      wayOn[w]   = NW_W'(w) < numWays;
      // a flush in this cycle makes the set look empty and freshly ordered
      curAge[w]  = strobes.flushAll ? WAY_W'(w) : ageArr[reqCore][setIdx][w];
      freeVec[w] = wayOn[w] && (strobes.flushAll || !validArr[reqCore][setIdx][w]);
      hitVec[w]  = wayOn[w] && !strobes.flushAll && validArr[reqCore][setIdx][w]
                   && (tagArr[reqCore][setIdx][w] == reqTag);
    end
    hitWay  = '0;
    freeWay = '0;
    lruWay  = '0;
    for (int w = MAX_WAYS - 1; w >= 0; w--) begin
      if (hitVec[w]) hitWay = WAY_W'(w);
      if (freeVec[w]) freeWay = WAY_W'(w);
      if (wayOn[w] && (curAge[w] == WAY_W'(numWays - NW_W'(1)))) lruWay = WAY_W'(w);
    end
  end

  assign lookHit = |hitVec;
  assign anyFree = |freeVec;
  assign useWay  = lookHit ? hitWay : (anyFree ? freeWay : lruWay);
  assign useAge  = curAge[useWay];
  assign lookVictimDirty = !lookHit && !anyFree && dirtyArr[reqCore][setIdx][lruWay];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CORES; c++)
        for (int s = 0; s < MAX_SETS; s++)
          for (int w = 0; w < MAX_WAYS; w++) begin
            tagArr[c][s][w]   <= '0;
            validArr[c][s][w] <= 1'b0;
            dirtyArr[c][s][w] <= 1'b0;
            ageArr[c][s][w]   <= WAY_W'(w);
          end
    end else begin
      if (strobes.flushAll) begin
        for (int c = 0; c < NUM_CORES; c++)
          for (int s = 0; s < MAX_SETS; s++)
            for (int w = 0; w < MAX_WAYS; w++) begin
              validArr[c][s][w] <= 1'b0;
              dirtyArr[c][s][w] <= 1'b0;
              ageArr[c][s][w]   <= WAY_W'(w);
            end
      end
      if (strobes.access) begin
        for (int w = 0; w < MAX_WAYS; w++) begin
          if (wayOn[w]) begin
            if (WAY_W'(w) == useWay)
              ageArr[reqCore][setIdx][w] <= '0;
            else if (curAge[w] < useAge)
              ageArr[reqCore][setIdx][w] <= curAge[w] + WAY_W'(1);
            else
              ageArr[reqCore][setIdx][w] <= curAge[w];
          end
        end
        if (lookHit) begin
          if (strobes.storeOp) dirtyArr[reqCore][setIdx][useWay] <= 1'b1;
        end else begin
          tagArr[reqCore][setIdx][useWay]   <= reqTag;
          validArr[reqCore][setIdx][useWay] <= 1'b1;
          dirtyArr[reqCore][setIdx][useWay] <= strobes.storeOp;
        end
      end
    end
  end
endmodule

// File: rtl/cacheCtrl.sv
module cacheCtrl
  import cacheModelPkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int CORE_W        = 2,
  parameter int MAX_SETS_LOG2 = 4,
  parameter int MAX_WAYS_LOG2 = 2,
  parameter int SCFG_W        = 3,
  parameter int WCFG_W        = 2,
  parameter int LCFG_W        = 3,
  parameter int PEN_W         = 16,
  parameter int STALL_W       = 17,
  parameter int CNT_W         = 16
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [SCFG_W-1:0]          cfgSetsLog2,
  input  logic [WCFG_W-1:0]          cfgWaysLog2,
  input  logic [LCFG_W-1:0]          cfgLineLog2,
  input  logic [PEN_W-1:0]           cfgMissPenalty,
  input  logic [PEN_W-1:0]           cfgWbPenalty,
  input  logic                       reqValid,
  input  logic [CORE_W-1:0]          reqCore,
  input  logic                       reqStore,
  input  logic                       statClear,
  input  logic                       lookHit,
  input  logic                       lookVictimDirty,
  output tagStrobe_t                 strobes,
  output logic [SCFG_W-1:0]          setsLog2Eff,
  output logic [WCFG_W-1:0]          waysLog2Eff,
  output logic                       respValid,
  output logic [CORE_W-1:0]          respCore,
  output logic                       respHit,
  output logic [STALL_W-1:0]         respStall,
  output logic [NUM_CORES*CNT_W-1:0] hitCount,
  output logic [NUM_CORES*CNT_W-1:0] missCount
);
  localparam int GEOM_W = SCFG_W + WCFG_W + LCFG_W;

  logic [GEOM_W-1:0] geomNow, geomPrev;

  assign setsLog2Eff = (cfgSetsLog2 > SCFG_W'(MAX_SETS_LOG2)) ? SCFG_W'(MAX_SETS_LOG2) : cfgSetsLog2;
  assign waysLog2Eff = (cfgWaysLog2 > WCFG_W'(MAX_WAYS_LOG2)) ? WCFG_W'(MAX_WAYS_LOG2) : cfgWaysLog2;
  assign geomNow     = {setsLog2Eff, waysLog2Eff, cfgLineLog2};

  assign strobes.flushAll = (geomNow != geomPrev);
  assign strobes.access   = reqValid;
  assign strobes.storeOp  = reqStore;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) geomPrev <= '0;
    else       geomPrev <= geomNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respCore  <= '0;
      respHit   <= 1'b0;
      respStall <= '0;
    end else begin
      respValid <= reqValid;
      if (reqValid) begin
        respCore <= reqCore;
        respHit  <= lookHit;
        if (lookHit)
          respStall <= '0;
        else
          respStall <= STALL_W'(cfgMissPenalty)
                       + (lookVictimDirty ? STALL_W'(cfgWbPenalty) : STALL_W'(0));
      end
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_cnt
    logic [CNT_W-1:0] hitCnt, missCnt;
    logic             mine;
    assign mine = reqValid && (reqCore == CORE_W'(c));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        hitCnt  <= '0;
        missCnt <= '0;
      end else if (statClear) begin
        hitCnt  <= '0;
        missCnt <= '0;
      end else if (mine) begin
        if (lookHit) hitCnt  <= hitCnt + CNT_W'(1);
        else         missCnt <= missCnt + CNT_W'(1);
      end
    end
    assign hitCount[c*CNT_W +: CNT_W]  = hitCnt;
    assign missCount[c*CNT_W +: CNT_W] = missCnt;
  end
endmodule

// File: rtl/cacheTimingModel.sv
module cacheTimingModel
  import cacheModelPkg::*;
#(
  parameter int NUM_CORES     = 4,
  parameter int ADDR_W        = 32,
  parameter int MAX_SETS_LOG2 = 4,
  parameter int MAX_WAYS_LOG2 = 2,
  parameter int LCFG_W        = 3,
  parameter int PEN_W         = 16,
  parameter int CNT_W         = 16,
  localparam int CORE_W       = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
  localparam int SCFG_W       = $clog2(MAX_SETS_LOG2 + 2),
  localparam int WCFG_W       = $clog2(MAX_WAYS_LOG2 + 2),
  localparam int STALL_W      = PEN_W + 1
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [SCFG_W-1:0]          cfgSetsLog2,
  input  logic [WCFG_W-1:0]          cfgWaysLog2,
  input  logic [LCFG_W-1:0]          cfgLineLog2,
  input  logic [PEN_W-1:0]           cfgMissPenalty,
  input  logic [PEN_W-1:0]           cfgWbPenalty,
  input  logic                       reqValid,
  input  logic [CORE_W-1:0]          reqCore,
  input  logic [ADDR_W-1:0]          reqAddr,
  input  logic                       reqStore,
  input  logic                       statClear,
  output logic                       respValid,
  output logic [CORE_W-1:0]          respCore,
  output logic                       respHit,
  output logic [STALL_W-1:0]         respStall,
  output logic [NUM_CORES*CNT_W-1:0] hitCount,
  output logic [NUM_CORES*CNT_W-1:0] missCount
);
  tagStrobe_t        strobes;
  logic [SCFG_W-1:0] setsLog2Eff;
  logic [WCFG_W-1:0] waysLog2Eff;
  logic              lookHit, lookVictimDirty;

  cacheCtrl #(
    .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .MAX_SETS_LOG2(MAX_SETS_LOG2),
    .MAX_WAYS_LOG2(MAX_WAYS_LOG2), .SCFG_W(SCFG_W), .WCFG_W(WCFG_W), .LCFG_W(LCFG_W),
    .PEN_W(PEN_W), .STALL_W(STALL_W), .CNT_W(CNT_W)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .cfgSetsLog2(cfgSetsLog2), .cfgWaysLog2(cfgWaysLog2), .cfgLineLog2(cfgLineLog2),
    .cfgMissPenalty(cfgMissPenalty), .cfgWbPenalty(cfgWbPenalty),
    .reqValid(reqValid), .reqCore(reqCore), .reqStore(reqStore), .statClear(statClear),
    .lookHit(lookHit), .lookVictimDirty(lookVictimDirty),
    .strobes(strobes), .setsLog2Eff(setsLog2Eff), .waysLog2Eff(waysLog2Eff),
    .respValid(respValid), .respCore(respCore), .respHit(respHit), .respStall(respStall),
    .hitCount(hitCount), .missCount(missCount)
  );

  cacheTagStore #(
    .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .ADDR_W(ADDR_W),
    .MAX_SETS_LOG2(MAX_SETS_LOG2), .MAX_WAYS_LOG2(MAX_WAYS_LOG2),
    .SCFG_W(SCFG_W), .WCFG_W(WCFG_W), .LCFG_W(LCFG_W)
  ) i_tags (
    .clk(clk), .rstN(rstN), .strobes(strobes), .reqCore(reqCore), .reqAddr(reqAddr),
    .setsLog2(setsLog2Eff), .waysLog2(waysLog2Eff), .lineLog2(cfgLineLog2),
    .lookHit(lookHit), .lookVictimDirty(lookVictimDirty)
  );
endmodule

// File: rtl/cacheTimingModelChk.sv
module cacheTimingModelChk #(
  parameter int NUM_CORES = 4,
  parameter int CORE_W    = 2,
  parameter int PEN_W     = 16,
  parameter int STALL_W   = 17,
  parameter int CNT_W     = 16
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       reqValid,
  input logic [CORE_W-1:0]          reqCore,
  input logic                       statClear,
  input logic [PEN_W-1:0]           cfgMissPenalty,
  input logic [PEN_W-1:0]           cfgWbPenalty,
  input logic                       respValid,
  input logic [CORE_W-1:0]          respCore,
  input logic                       respHit,
  input logic [STALL_W-1:0]         respStall,
  input logic [NUM_CORES*CNT_W-1:0] hitCount,
  input logic [NUM_CORES*CNT_W-1:0] missCount
);
  AST_RESP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> respValid); // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !respValid); // R2
  AST_RESP_CORE_ECHO: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> (respCore == $past(reqCore))); // R2
  AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && respHit) |-> (respStall == '0)); // R3
  AST_MISS_PENALTY: assert property (@(posedge clk) disable iff (!rstN)
    (respValid && !respHit) |->
      ((respStall == STALL_W'($past(cfgMissPenalty))) ||
       (respStall == STALL_W'($past(cfgMissPenalty)) + STALL_W'($past(cfgWbPenalty))))); // R4
  AST_STAT_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    statClear |=> ((hitCount == '0) && (missCount == '0))); // R11
endmodule

bind cacheTimingModel cacheTimingModelChk #(
  .NUM_CORES(NUM_CORES), .CORE_W(CORE_W), .PEN_W(PEN_W), .STALL_W(STALL_W), .CNT_W(CNT_W)
) i_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqCore(reqCore), .statClear(statClear),
  .cfgMissPenalty(cfgMissPenalty), .cfgWbPenalty(cfgWbPenalty),
  .respValid(respValid), .respCore(respCore), .respHit(respHit), .respStall(respStall),
  .hitCount(hitCount), .missCount(missCount)
);

// File: tb/test_cacheTimingModel.sv
`timescale 1ns/1ps
module test_cacheTimingModel;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  cfgSetsLog2 = 3'd2;
  logic [1:0]  cfgWaysLog2 = 2'd0;
  logic [2:0]  cfgLineLog2 = 3'd4;
  logic [15:0] cfgMissPenalty = 16'd20;
  logic [15:0] cfgWbPenalty = 16'd7;
  logic        reqValid = 1'b0;
  logic [1:0]  reqCore = '0;
  logic [31:0] reqAddr = '0;
  logic        reqStore = 1'b0;
  logic        statClear = 1'b0;
  logic        respValid;
  logic [1:0]  respCore;
  logic        respHit;
  logic [16:0] respStall;
  logic [63:0] hitCount, missCount;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  cacheTimingModel i_cacheTimingModel (
    .clk(clk), .rstN(rstN),
    .cfgSetsLog2(cfgSetsLog2), .cfgWaysLog2(cfgWaysLog2), .cfgLineLog2(cfgLineLog2),
    .cfgMissPenalty(cfgMissPenalty), .cfgWbPenalty(cfgWbPenalty),
    .reqValid(reqValid), .reqCore(reqCore), .reqAddr(reqAddr), .reqStore(reqStore),
    .statClear(statClear),
    .respValid(respValid), .respCore(respCore), .respHit(respHit), .respStall(respStall),
    .hitCount(hitCount), .missCount(missCount)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one request, response sampled at the following falling edge
  task automatic access(input int core, input logic [31:0] addr, input logic st,
                        input logic expHit, input int expStall, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqCore = 2'(core); reqAddr = addr; reqStore = st;
    @(negedge clk);
    reqValid = 1'b0; reqStore = 1'b0;
    check(respValid === 1'b1 && respCore === 2'(core), "R2 response",
          {respValid, respCore}, {1'b1, 2'(core)});
    check(respHit === expHit, {req, " hit"}, respHit, expHit);
    check(respStall === 17'(expStall), {req, " stall"}, respStall, expStall);
  endtask

  task automatic setCfg(input int waysL2, input int missP);
    @(negedge clk);
    cfgWaysLog2 = 2'(waysL2); cfgMissPenalty = 16'(missP);
    @(negedge clk);
    check(respValid === 1'b0, "R2 idle", respValid, 0);
  endtask

  task automatic tReset();
    check(respValid === 1'b0, "R1 respValid", respValid, 0);
    check(hitCount === '0 && missCount === '0, "R1 counters", hitCount | missCount, 0);
  endtask

  task automatic tDirectMapped();
    access(0, 32'h100, 0, 0, 20, "R4 cold miss");
    access(0, 32'h10C, 0, 1, 0, "R3 R6 offset hit");
    access(0, 32'h140, 0, 0, 20, "R7 conflict miss");
    access(0, 32'h110, 0, 0, 20, "R6 other set miss");
    access(0, 32'h140, 0, 1, 0, "R6 set isolation");
    access(0, 32'h100, 0, 0, 20, "R7 evicted line");
  endtask

  task automatic tDirty();
    access(0, 32'h200, 1, 0, 20, "R5 store miss clean victim");
    access(0, 32'h100, 0, 0, 27, "R5 dirty eviction");
    access(0, 32'h100, 1, 1, 0, "R5 store hit");
    access(0, 32'h140, 0, 0, 27, "R5 store-hit dirty eviction");
  endtask

  task automatic tCores();
    access(1, 32'h140, 0, 0, 20, "R9 other core misses");
    access(0, 32'h140, 0, 1, 0, "R9 own core hits");
  endtask

  task automatic tAssocLru();
    setCfg(2, 20);
    access(0, 32'h140, 0, 0, 20, "R10 flushed on geometry change");
    access(0, 32'h100, 0, 0, 20, "R8 fill free way");
    access(0, 32'h180, 0, 0, 20, "R8 fill free way");
    access(0, 32'h1C0, 0, 0, 20, "R8 fill free way");
    access(0, 32'h140, 0, 1, 0, "R7 four ways coexist");
    access(0, 32'h100, 0, 1, 0, "R7 four ways coexist");
    access(0, 32'h180, 0, 1, 0, "R7 four ways coexist");
    access(0, 32'h1C0, 0, 1, 0, "R7 four ways coexist");
    access(0, 32'h140, 0, 1, 0, "R8 refresh");
    access(0, 32'h200, 0, 0, 20, "R8 lru fill");
    access(0, 32'h140, 0, 1, 0, "R8 refreshed line kept");
    access(0, 32'h180, 0, 1, 0, "R8 kept");
    access(0, 32'h1C0, 0, 1, 0, "R8 kept");
    access(0, 32'h200, 0, 1, 0, "R8 new line present");
    access(0, 32'h100, 0, 0, 20, "R8 lru line was victim");
  endtask

  task automatic tPenaltyOnly();
    setCfg(2, 33);
    access(0, 32'h200, 0, 1, 0, "R10 penalty change keeps lines");
    access(0, 32'h240, 0, 0, 33, "R4 new penalty");
  endtask

  task automatic tClamp();
    setCfg(0, 33);
    setCfg(3, 33);
    access(0, 32'h100, 0, 0, 33, "R12 clamped fill");
    access(0, 32'h140, 0, 0, 33, "R12 clamped fill");
    access(0, 32'h180, 0, 0, 33, "R12 clamped fill");
    access(0, 32'h1C0, 0, 0, 33, "R12 clamped fill");
    access(0, 32'h100, 0, 1, 0, "R12 acts as four ways");
    access(0, 32'h1C0, 0, 1, 0, "R12 acts as four ways");
  endtask

  task automatic tStats();
    @(negedge clk); statClear = 1'b1;
    @(negedge clk); statClear = 1'b0;
    check(hitCount === '0 && missCount === '0, "R11 clear", hitCount | missCount, 0);
    access(2, 32'h300, 0, 0, 33, "R11 traffic");
    access(2, 32'h304, 0, 1, 0, "R11 traffic");
    access(2, 32'h308, 0, 1, 0, "R11 traffic");
    access(3, 32'h300, 0, 0, 33, "R11 traffic");
    check(hitCount[47:32] === 16'd2, "R11 core2 hits", hitCount[47:32], 2);
    check(missCount[47:32] === 16'd1, "R11 core2 misses", missCount[47:32], 1);
    check(missCount[63:48] === 16'd1, "R11 core3 misses", missCount[63:48], 1);
    check(hitCount[15:0] === 16'd0 && missCount[15:0] === 16'd0, "R11 core0 untouched",
          hitCount[15:0] | missCount[15:0], 0);
    @(negedge clk);
    statClear = 1'b1; reqValid = 1'b1; reqCore = 2'd2; reqAddr = 32'h300;
    @(negedge clk);
    statClear = 1'b0; reqValid = 1'b0;
    check(respHit === 1'b1, "R11 concurrent hit", respHit, 1);
    check(hitCount === '0 && missCount === '0, "R11 clear wins", hitCount | missCount, 0);
  endtask

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    tReset();
    tDirectMapped();
    tDirty();
    tCores();
    tAssocLru();
    tPenaltyOnly();
    tClamp();
    tStats();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule